// File: doc/BRIEF.md
# Two-Stage Instruction Fetch with Redirect Kill

This block is the front end of a small 16-bit processor that runs in two stages: a fetch stage and one execute stage, which decodes, executes and writes back. The block keeps the fetch program counter and drives it out as the fetch address. Each cycle it captures the returned 16-bit instruction word into a pipeline slot, along with the address it came from. The execute stage reads the instruction and its PC from that slot.

The execute-stage decoder reports a redirect kind for the instruction it holds: none, absolute jump, register jump or conditional branch. With the kind it supplies the immediates, the source register value and the branch comparison result. From these the block works out the next fetch address. There are no delay slots. On any jump, or on a branch that is taken, the word being fetched in that cycle belongs to the wrong path. The block then loads the all-zero no-operation word into the slot in its place. A branch that is not taken leaves the instruction stream as it is. The block also gives the link address for the instruction in execute.

Top module: `ifetch_kill`

## Requirements
- R1: While reset is high at a clock edge, the fetch address, the slot instruction and the slot PC all become 0x0000. The first execute cycle after reset therefore holds a no-operation.
- R2: In a cycle with no redirect, the fetch address advances by 2 at the next edge and wraps modulo 2^16.
- R3: In a cycle without kill, the slot instruction takes the fetched word at the next edge, and the slot PC takes the fetch address of that cycle.
- R4: The kill output is high in every cycle where redir_kind is 1 (jump) or 2 (register jump). At the next edge the slot instruction becomes 0x0000.
- R5: When redir_kind is 3 (branch), kill follows branch_taken. A taken branch loads 0x0000 into the slot. A branch that is not taken behaves exactly like a cycle with no redirect.
- R6: For a jump, the next fetch address is ex_pc[15:10] concatenated with the 10-bit jump_imm.
- R7: For a register jump, the next fetch address is rs_value plus off_imm, where the 6-bit off_imm is sign-extended and the sum is taken modulo 2^16.
- R8: For a taken branch, the next fetch address is ex_pc plus the sign-extended off_imm, read as a byte offset, modulo 2^16.
- R9: link_addr always equals ex_pc + 2, modulo 2^16.
- R10: When redir_kind is 0 (none), branch_taken has no effect on kill, on the fetch address or on the slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetch_addr | output | 16 | Address presented to instruction memory |
| fetch_instr | input | 16 | Instruction word returned for fetch_addr |
| ex_instr | output | 16 | Instruction held for the execute stage |
| ex_pc | output | 16 | Address of the instruction held for execute |
| redir_kind | input | 2 | Redirect kind from decode: 0 none, 1 jump, 2 register jump, 3 branch |
| jump_imm | input | 10 | Immediate of an absolute jump |
| off_imm | input | 6 | Signed byte offset for a register jump or a branch |
| rs_value | input | 16 | Source register value for a register jump |
| branch_taken | input | 1 | Branch comparison result |
| kill | output | 1 | High when the instruction fetched this cycle is squashed |
| link_addr | output | 16 | Return address for the instruction in execute |

## Verification
The bound checker watches several relations on every cycle:
- the slot loads the fetched word or the no-operation word, depending on kill;
- the address steps by two when there is no redirect;
- the slot PC follows the previous fetch address;
- each of the three target formulas holds;
- a branch that is not taken never kills.

The bench adds what per-cycle properties cannot show well. It sweeps every 6-bit offset for branch and register-jump targets, including the wrap at both ends of the address space, and covers many jump immediates. It runs long sequential stretches through the 0xFFFE to 0x0000 rollover. It also checks end to end that a stray branch_taken with no redirect leaves the stream unchanged.

// File: rtl/ifetch_pkg.sv
package ifetch_pkg;

    localparam int ADDR_W   = 16;
    localparam int JIMM_W   = 10;
    localparam int OIMM_W   = 6;

    typedef enum logic [1:0] {
        RK_NONE   = 2'd0,
        RK_JUMP   = 2'd1,
        RK_JREG   = 2'd2,
        RK_BRANCH = 2'd3
    } redir_kind_e;

endpackage

// File: rtl/ifetch_target.sv
module ifetch_target
    import ifetch_pkg::*;
#(
    parameter int XLEN = ADDR_W,
    parameter int JW   = JIMM_W,
    parameter int OW   = OIMM_W
) (
    input  redir_kind_e      kind,
    input  logic             taken,
    input  logic [XLEN-1:0]  cur_pc,
    input  logic [XLEN-1:0]  base_reg,
    input  logic [JW-1:0]    jimm,
    input  logic [OW-1:0]    oimm,
    output logic             squash,
    output logic [XLEN-1:0]  target,
    output logic [XLEN-1:0]  link
);
    localparam int EXT_W = XLEN - OW;
    localparam logic [XLEN-1:0] STEP = XLEN'(2);

    logic [XLEN-1:0] off_sx;

    always_comb begin
        off_sx = {{EXT_W{oimm[OW-1]}}, oimm};
        link   = cur_pc + STEP;
        squash = 1'b0;
        target = '0;
        unique case (kind)
            RK_JUMP: begin
                squash = 1'b1;
                target = {cur_pc[XLEN-1:JW], jimm};
            end
            RK_JREG: begin
                squash = 1'b1;
                target = base_reg + off_sx;
            end
            RK_BRANCH: begin
                squash = taken;
                target = cur_pc + off_sx;
            end
            default: begin
                squash = 1'b0;
                target = '0;
            end
        endcase
    end
endmodule

// File: rtl/ifetch_pipe.sv
module ifetch_pipe #(
    parameter int XLEN = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             squash,
    input  logic [XLEN-1:0]  target,
    input  logic [XLEN-1:0]  word_in,
    output logic [XLEN-1:0]  pc_q,
    output logic [XLEN-1:0]  slot_instr,
    output logic [XLEN-1:0]  slot_pc
);
    localparam logic [XLEN-1:0] STEP = XLEN'(2);

    typedef struct packed {
        logic [XLEN-1:0] instr;
        logic [XLEN-1:0] pc;
    } slot_t;

    slot_t slot_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q   <= '0;
            slot_q <= '0;
        end else begin
            pc_q         <= squash ? target : pc_q + STEP;
            slot_q.instr <= squash ? '0 : word_in;
            slot_q.pc    <= pc_q;
        end
    end

    assign slot_instr = slot_q.instr;
    assign slot_pc    = slot_q.pc;
endmodule

// File: rtl/ifetch_kill.sv
module ifetch_kill
    import ifetch_pkg::*;
#(
    parameter int XLEN = ADDR_W,
    parameter int JW   = JIMM_W,
    parameter int OW   = OIMM_W
) (
    input  logic            clk,
    input  logic            rst,
    output logic [XLEN-1:0] fetch_addr,
    input  logic [XLEN-1:0] fetch_instr,
    output logic [XLEN-1:0] ex_instr,
    output logic [XLEN-1:0] ex_pc,
    input  logic [1:0]      redir_kind,
    input  logic [JW-1:0]   jump_imm,
    input  logic [OW-1:0]   off_imm,
    input  logic [XLEN-1:0] rs_value,
    input  logic            branch_taken,
    output logic            kill,
    output logic [XLEN-1:0] link_addr
);
    logic [XLEN-1:0] next_tgt;

    ifetch_target #(.XLEN(XLEN), .JW(JW), .OW(OW)) u_tgt (
        .kind     (redir_kind_e'(redir_kind)),
        .taken    (branch_taken),
        .cur_pc   (ex_pc),
        .base_reg (rs_value),
        .jimm     (jump_imm),
        .oimm     (off_imm),
        .squash   (kill),
        .target   (next_tgt),
        .link     (link_addr)
    );

    ifetch_pipe #(.XLEN(XLEN)) u_pipe (
        .clk        (clk),
        .rst        (rst),
        .squash     (kill),
        .target     (next_tgt),
        .word_in    (fetch_instr),
        .pc_q       (fetch_addr),
        .slot_instr (ex_instr),
        .slot_pc    (ex_pc)
    );
endmodule

// File: rtl/ifetch_kill_chk.sv
module ifetch_kill_chk #(
    parameter int XLEN = 16,
    parameter int JW   = 10,
    parameter int OW   = 6
) (
    input logic            clk,
    input logic            rst,
    input logic [XLEN-1:0] fetch_addr,
    input logic [XLEN-1:0] fetch_instr,
    input logic [XLEN-1:0] ex_instr,
    input logic [XLEN-1:0] ex_pc,
    input logic [1:0]      redir_kind,
    input logic [JW-1:0]   jump_imm,
    input logic [OW-1:0]   off_imm,
    input logic [XLEN-1:0] rs_value,
    input logic            branch_taken,
    input logic            kill
);
    localparam int EXT_W = XLEN - OW;

    logic rst_d;
    always_ff @(posedge clk) rst_d <= rst;

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        rst_d |-> (fetch_addr == '0 && ex_instr == '0 && ex_pc == '0));

    assert_seq_step_R2: assert property (@(posedge clk) disable iff (rst)
        !kill |=> fetch_addr == $past(fetch_addr) + XLEN'(2));

    assert_slot_load_R3: assert property (@(posedge clk) disable iff (rst)
        !kill |=> (ex_instr == $past(fetch_instr) && ex_pc == $past(fetch_addr)));

    assert_jump_kill_R4: assert property (@(posedge clk) disable iff (rst)
        (redir_kind == 2'd1 || redir_kind == 2'd2) |=> ex_instr == '0);

    assert_no_taken_no_kill_R5: assert property (@(posedge clk) disable iff (rst)
        (redir_kind == 2'd3 && !branch_taken) |-> !kill);

    assert_jump_target_R6: assert property (@(posedge clk) disable iff (rst)
        redir_kind == 2'd1 |=>
            fetch_addr == {$past(ex_pc[XLEN-1:JW]), $past(jump_imm)});

    assert_jreg_target_R7: assert property (@(posedge clk) disable iff (rst)
        redir_kind == 2'd2 |=>
            fetch_addr == $past(rs_value) + {{EXT_W{$past(off_imm[OW-1])}}, $past(off_imm)});

    assert_branch_target_R8: assert property (@(posedge clk) disable iff (rst)
        (redir_kind == 2'd3 && branch_taken) |=>
            fetch_addr == $past(ex_pc) + {{EXT_W{$past(off_imm[OW-1])}}, $past(off_imm)});

    assert_idle_no_kill_R10: assert property (@(posedge clk) disable iff (rst)
        redir_kind == 2'd0 |-> !kill);
endmodule

bind ifetch_kill ifetch_kill_chk #(.XLEN(XLEN), .JW(JW), .OW(OW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .fetch_addr   (fetch_addr),
    .fetch_instr  (fetch_instr),
    .ex_instr     (ex_instr),
    .ex_pc        (ex_pc),
    .redir_kind   (redir_kind),
    .jump_imm     (jump_imm),
    .off_imm      (off_imm),
    .rs_value     (rs_value),
    .branch_taken (branch_taken),
    .kill         (kill)
);

// File: tb/tb_ifetch_kill.sv
module tb_ifetch_kill;
    localparam int CLK_P = 10;
    localparam logic [15:0] KEY = 16'hA5C3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] fetch_addr, fetch_instr, ex_instr, ex_pc, rs_value, link_addr;
    logic [1:0]  redir_kind = 2'd0;
    logic [9:0]  jump_imm = '0;
    logic [5:0]  off_imm = '0;
    logic        branch_taken = 1'b0;
    logic        kill;

    int n_cmp = 0;
    int n_bad = 0;
    logic [15:0] m_pc, m_expc, m_exi;

    always #(CLK_P/2) clk = ~clk;
    assign fetch_instr = fetch_addr ^ KEY;
    initial rs_value = '0;

    ifetch_kill dut (
        .clk(clk), .rst(rst), .fetch_addr(fetch_addr), .fetch_instr(fetch_instr),
        .ex_instr(ex_instr), .ex_pc(ex_pc), .redir_kind(redir_kind),
        .jump_imm(jump_imm), .off_imm(off_imm), .rs_value(rs_value),
        .branch_taken(branch_taken), .kill(kill), .link_addr(link_addr)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic [1:0] k, input logic [9:0] ji, input logic [5:0] oi,
                        input logic [15:0] rv, input logic tk, input string req);
        logic        kl;
        logic [15:0] tg, sx;
        redir_kind = k; jump_imm = ji; off_imm = oi; rs_value = rv; branch_taken = tk;
        #1;
        sx = {{10{oi[5]}}, oi};
        kl = (k == 2'd1) || (k == 2'd2) || (k == 2'd3 && tk);
        case (k)
            2'd1:    tg = {m_expc[15:10], ji};
            2'd2:    tg = rv + sx;
            2'd3:    tg = m_expc + sx;
            default: tg = m_pc + 16'd2;
        endcase
        chk({req, " kill"}, {15'b0, kill}, {15'b0, kl});
        chk("R9 link_addr", link_addr, m_expc + 16'd2);
        m_exi  = kl ? 16'h0000 : (m_pc ^ KEY);
        m_expc = m_pc;
        m_pc   = kl ? tg : m_pc + 16'd2;
        @(posedge clk);
        @(negedge clk);
        chk({req, " fetch_addr"}, fetch_addr, m_pc);
        chk({req, " ex_instr"}, ex_instr, m_exi);
        chk("R3 ex_pc", ex_pc, m_expc);
    endtask

    initial begin
        #(CLK_P * 200000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 fetch_addr", fetch_addr, 16'h0000);
        chk("R1 ex_instr", ex_instr, 16'h0000);
        chk("R1 ex_pc", ex_pc, 16'h0000);
        m_pc = 0; m_expc = 0; m_exi = 0;

        for (int i = 0; i < 20; i++) step(2'd0, '0, '0, '0, 1'b0, "R2");
        // R10: stray taken flag without a redirect
        for (int i = 0; i < 8; i++) step(2'd0, 10'(i * 91), 6'(i * 7), 16'h1234, 1'b1, "R10");
        // R6 / R4: jump immediates, ex_pc varied by preceding register jumps
        for (int i = 0; i < 64; i++) begin
            step(2'd2, '0, '0, 16'(i * 16'h0404 + 16'h0400), 1'b0, "R4");
            step(2'd0, '0, '0, '0, 1'b0, "R2");
            step(2'd1, 10'(i * 16 + i), '0, '0, 1'b0, "R6");
        end
        // R7: every offset for several base values, including wrap
        for (int r = 0; r < 4; r++) begin
            for (int i = 0; i < 64; i++) begin
                logic [15:0] bases [4] = '{16'h0000, 16'hFFF0, 16'h0010, 16'h7FFE};
                step(2'd2, '0, 6'(i), bases[r], 1'b0, "R7");
            end
        end
        // R8 / R5: every branch offset taken then not taken
        step(2'd2, '0, '0, 16'hFFE0, 1'b0, "R7");
        for (int i = 0; i < 64; i++) begin
            step(2'd3, '0, 6'(i), 16'hBEEF, 1'b1, "R8");
            step(2'd3, '0, 6'(i), 16'hBEEF, 1'b0, "R5");
        end
        step(2'd2, '0, '0, 16'h0008, 1'b0, "R7");
        for (int i = 0; i < 64; i++) step(2'd3, '0, 6'(i), '0, 1'b1, "R8");
        // R2 wrap of sequential fetch
        step(2'd2, '0, '0, 16'hFFF8, 1'b0, "R7");
        for (int i = 0; i < 10; i++) step(2'd0, '0, '0, '0, 1'b0, "R2");
        // R4 back-to-back jumps
        for (int i = 0; i < 4; i++) step(2'd1, 10'h3FF - 10'(i), '0, '0, 1'b0, "R4");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule